// File: doc/BRIEF.md
# File-Register Rotate/Fill Executor

This block runs two byte-wide instructions of a small accumulator-plus-register-file controller: a one-place right rotation with no carry, and a fill that loads all ones. A single instruction is accepted on a start strobe. It then passes through four fixed phases: decode, operand read, compute and write-back. During those phases the block is busy, and a one-cycle done pulse follows the last phase.

The 8-bit operand field of the instruction is turned into a 12-bit data address in one of three ways:
- through a shared window that splits low and high addresses,
- by prefixing the bank-select value,
- in indexed mode, by adding the field to an index base.

The result goes either to the working register or back to the addressed location, and the sign and zero flags track rotation results. Register-file access uses one synchronous read port and one write strobe. Fetch, the program counter and every other opcode belong to other blocks.

Top module: `freg_exec`

## Requirements
- R1: A rotate instruction (instr[15:10] = 010000) produces a result whose bit n-1 is operand bit n and whose bit 7 is operand bit 0.
- R2: For a rotate, instr[9] = 0 sends the result to the working register and leaves the file location unwritten. instr[9] = 1 writes the result back to the location and leaves the working register unchanged.
- R3: After a rotate, flag_n equals result bit 7 and flag_z is 1 exactly when the result is 00h.
- R4: A fill instruction (instr[15:9] = 0110100) writes FFh to the addressed location and changes neither the flags nor the working register.
- R5: With instr[8] = 1, the data address is {bank_sel, instr[7:0]}.
- R6: With instr[8] = 0 and indexed mode not in effect, the bank-select value is ignored. Field values 00h–5Fh address 000h–05Fh, and 60h–FFh address F60h–FFFh.
- R7: Indexed mode applies when instr[8] = 0, ext_en = 1 and the field is at most 5Fh. The address is then (idx_base + field) modulo 4096. A field of 60h or above, or instr[8] = 1, is never indexed.
- R8: After an accepted start, busy is high for exactly four cycles. rf_rd_en is high in the second of them only, and rf_we can be high in the fourth only. done is high for the single cycle after the fourth, and at that point the working register and flags already show the result.
- R9: Any other opcode still takes four busy cycles. It writes nothing to the file, the working register or the flags.
- R10: A start raised while busy is ignored. It neither changes the running instruction nor begins another one.
- R11: After reset, busy, done, rf_rd_en, rf_we, flag_n and flag_z are 0, and the working register holds 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept instr when idle |
| instr | input | 16 | Instruction word |
| ext_en | input | 1 | Enables indexed addressing |
| bank_sel | input | 4 | Bank-select value |
| idx_base | input | 12 | Base for indexed addressing |
| rf_addr | output | 12 | Register-file address |
| rf_rd_en | output | 1 | Read strobe; data returns next cycle |
| rf_rdata | input | 8 | Read data |
| rf_we | output | 1 | Write strobe |
| rf_wdata | output | 8 | Write data |
| w_q | output | 8 | Working register |
| flag_n | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong phase count or a stuck sequencer shows up as a read or write strobe landing in the wrong cycle within the same four-cycle window. The reference model checks the strobes every cycle, so such a fault is caught before done. A mis-resolved address appears on rf_addr in the read phase and is compared right there. A bad result or flag update shows at the done cycle as a mismatched working register, flag or memory byte. A wrongly accepted start shows up as busy rising again right after done.

// File: rtl/freg_exec_pkg.sv
package freg_exec_pkg;

    parameter int FR_DW = 8;
    parameter int FR_IW = 16;

    localparam logic [5:0] OPC_ROR = 6'b010000;   // instr[15:10]
    localparam logic [6:0] OPC_SET = 7'b0110100;  // instr[15:9]

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_Q1   = 3'd1,
        PH_Q2   = 3'd2,
        PH_Q3   = 3'd3,
        PH_Q4   = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ROR  = 2'd1,
        OP_SET  = 2'd2
    } op_e;

    typedef struct packed {
        op_e              op;
        logic             to_file;
        logic             use_bank;
        logic [FR_DW-1:0] fld;
    } dec_t;

    typedef struct packed {
        logic [FR_DW-1:0] res;
        logic             n;
        logic             z;
        logic             flag_we;
    } alu_t;

    function automatic logic [FR_DW-1:0] ror1(input logic [FR_DW-1:0] v);
        return {v[0], v[FR_DW-1:1]};
    endfunction

endpackage

// File: rtl/freg_decode.sv
module freg_decode
    import freg_exec_pkg::*;
(
    input  logic [FR_IW-1:0] instr,
    output dec_t             dec
);
    always_comb begin
        dec          = '0;
        dec.op       = OP_NONE;
        dec.fld      = instr[FR_DW-1:0];
        dec.use_bank = instr[8];
        if (instr[FR_IW-1:10] == OPC_ROR) begin
            dec.op      = OP_ROR;
            dec.to_file = instr[9];
        end else if (instr[FR_IW-1:9] == OPC_SET) begin
            dec.op      = OP_SET;
            dec.to_file = 1'b1;
        end
    end
endmodule

// File: rtl/freg_addr_resolve.sv
module freg_addr_resolve #(
    parameter int AW    = 12,
    parameter int DW    = 8,
    parameter int SPLIT = 8'h60
) (
    input  logic [DW-1:0]    fld,
    input  logic             use_bank,
    input  logic             ext_en,
    input  logic [AW-DW-1:0] bank,
    input  logic [AW-1:0]    idx_base,
    output logic [AW-1:0]    addr,
    output logic             indexed
);
    localparam int BW = AW - DW;
    localparam logic [DW-1:0] SPLIT_V = DW'(SPLIT);

    logic low_half;

    always_comb begin
        low_half = (fld < SPLIT_V);
        indexed  = !use_bank && ext_en && low_half;
        if (use_bank) begin
            addr = {bank, fld};
        end else if (indexed) begin
            addr = idx_base + {{BW{1'b0}}, fld};
        end else if (low_half) begin
            addr = {{BW{1'b0}}, fld};
        end else begin
            addr = {{BW{1'b1}}, fld};
        end
    end
endmodule

// File: rtl/freg_alu.sv
module freg_alu
    import freg_exec_pkg::*;
(
    input  op_e              op,
    input  logic [FR_DW-1:0] opnd,
    output alu_t             out
);
    always_comb begin
        out = '0;
        unique case (op)
            OP_ROR: begin
                out.res     = ror1(opnd);
                out.flag_we = 1'b1;
            end
            OP_SET: begin
                out.res     = '1;
                out.flag_we = 1'b0;
            end
            default: begin
                out.res     = opnd;
                out.flag_we = 1'b0;
            end
        endcase
        out.n = out.res[FR_DW-1];
        out.z = (out.res == '0);
    end
endmodule

// File: rtl/freg_exec.sv
module freg_exec
    import freg_exec_pkg::*;
#(
    parameter int AW    = 12,
    parameter int SPLIT = 8'h60
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [FR_IW-1:0]    instr,
    input  logic                ext_en,
    input  logic [AW-FR_DW-1:0] bank_sel,
    input  logic [AW-1:0]       idx_base,
    output logic [AW-1:0]       rf_addr,
    output logic                rf_rd_en,
    input  logic [FR_DW-1:0]    rf_rdata,
    output logic                rf_we,
    output logic [FR_DW-1:0]    rf_wdata,
    output logic [FR_DW-1:0]    w_q,
    output logic                flag_n,
    output logic                flag_z,
    output logic                busy,
    output logic                done
);
    localparam int DW = FR_DW;

    phase_e         phase_q;
    logic [FR_IW-1:0] instr_q;
    dec_t           dec_now, dec_q;
    logic [AW-1:0]  addr_now, addr_q;
    logic           idx_now;
    alu_t           alu_now, alu_q;
    logic           done_q;

    freg_decode u_dec (
        .instr (instr_q),
        .dec   (dec_now)
    );

    freg_addr_resolve #(.AW(AW), .DW(DW), .SPLIT(SPLIT)) u_addr (
        .fld      (dec_now.fld),
        .use_bank (dec_now.use_bank),
        .ext_en   (ext_en),
        .bank     (bank_sel),
        .idx_base (idx_base),
        .addr     (addr_now),
        .indexed  (idx_now)
    );

    freg_alu u_alu (
        .op   (dec_q.op),
        .opnd (rf_rdata),
        .out  (alu_now)
    );

    // Phase sequencer: IDLE -> Q1 -> Q2 -> Q3 -> Q4 -> IDLE
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            instr_q <= '0;
            dec_q   <= '0;
            addr_q  <= '0;
            alu_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= (phase_q == PH_Q4);
            unique case (phase_q)
                PH_IDLE: if (start) begin
                    instr_q <= instr;
                    phase_q <= PH_Q1;
                end
                PH_Q1: begin
                    dec_q   <= dec_now;
                    addr_q  <= addr_now;
                    phase_q <= PH_Q2;
                end
                PH_Q2: phase_q <= PH_Q3;
                PH_Q3: begin
                    alu_q   <= alu_now;
                    phase_q <= PH_Q4;
                end
                PH_Q4: phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Working register and flags, committed at the end of Q4
    always_ff @(posedge clk) begin
        if (rst) begin
            w_q    <= '0;
            flag_n <= 1'b0;
            flag_z <= 1'b0;
        end else if (phase_q == PH_Q4) begin
            if (alu_q.flag_we) begin
                flag_n <= alu_q.n;
                flag_z <= alu_q.z;
            end
            if (dec_q.op == OP_ROR && !dec_q.to_file) begin
                w_q <= alu_q.res;
            end
        end
    end

    always_comb begin
        rf_addr  = addr_q;
        rf_rd_en = (phase_q == PH_Q2);
        rf_we    = (phase_q == PH_Q4) && (dec_q.op != OP_NONE) && dec_q.to_file;
        rf_wdata = alu_q.res;
        busy     = (phase_q != PH_IDLE);
        done     = done_q;
    end

    // ---------------- assertions ----------------
    assert_write_after_read_R8: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> $past(rf_rd_en, 2));

    assert_read_single_R8: assert property (@(posedge clk) disable iff (rst)
        rf_rd_en |=> !rf_rd_en);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));

    assert_rot_result_R1: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_Q3 && dec_q.op == OP_ROR) |=>
            (rf_wdata == {$past(rf_rdata[0]), $past(rf_rdata[DW-1:1])}));

    assert_rot_flags_R3: assert property (@(posedge clk) disable iff (rst)
        (rf_rd_en && dec_q.op == OP_ROR) |=> ##2
            (flag_z == ($past(rf_rdata, 2) == '0) && flag_n == $past(rf_rdata[0], 2)));

    assert_set_flags_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_Q4 && dec_q.op == OP_SET) |=>
            (flag_n == $past(flag_n) && flag_z == $past(flag_z) && w_q == $past(w_q)));

    assert_unknown_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_Q4 && dec_q.op == OP_NONE) |=>
            (w_q == $past(w_q) && flag_n == $past(flag_n) && flag_z == $past(flag_z)));

    assert_bank_addr_R5: assert property (@(posedge clk) disable iff (rst)
        (rf_rd_en && dec_q.use_bank) |-> (rf_addr == {$past(bank_sel), dec_q.fld}));

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (instr_q == $past(instr_q)));

endmodule

// File: tb/freg_exec_test.sv
`timescale 1ns/1ps
module freg_exec_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [15:0] instr;
    logic        ext_en;
    logic [3:0]  bank_sel;
    logic [11:0] idx_base;
    logic [11:0] rf_addr;
    logic        rf_rd_en;
    logic [7:0]  rf_rdata;
    logic        rf_we;
    logic [7:0]  rf_wdata;
    logic [7:0]  w_q;
    logic        flag_n, flag_z, busy, done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [7:0] mem [int];
    logic [7:0] exp_w = 8'h00;
    logic       exp_n = 1'b0;
    logic       exp_z = 1'b0;

    always #4 clk = ~clk;

    freg_exec uut (
        .clk(clk), .rst(rst), .start(start), .instr(instr), .ext_en(ext_en),
        .bank_sel(bank_sel), .idx_base(idx_base), .rf_addr(rf_addr),
        .rf_rd_en(rf_rd_en), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_wdata(rf_wdata), .w_q(w_q), .flag_n(flag_n), .flag_z(flag_z),
        .busy(busy), .done(done)
    );

    function automatic logic [7:0] rd(input int a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    always @(posedge clk) begin
        if (rf_rd_en) rf_rdata <= rd(int'(rf_addr));
        if (rf_we) mem[int'(rf_addr)] = rf_wdata;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_addr(input logic [15:0] ins);
        int f;
        f = int'(ins[7:0]);
        if (ins[8]) return int'(bank_sel) * 256 + f;
        if (ext_en && f <= 95) return (int'(idx_base) + f) % 4096;
        if (f < 96) return f;
        return 3840 + f;
    endfunction

    // Runs one instruction; called right after a falling edge.
    task automatic run(input logic [15:0] ins, input bit poke);
        int   ea;
        bit   is_ror, is_set;
        logic [7:0] old, res;
        logic [7:0] exp_mem;
        is_ror = (ins[15:10] == 6'b010000);
        is_set = (ins[15:9] == 7'b0110100);
        ea  = exp_addr(ins);
        old = rd(ea);
        res = is_ror ? {old[0], old[7:1]} : 8'hFF;
        exp_mem = old;
        start = 1'b1;
        instr = ins;
        @(negedge clk); // Q1
        start = 1'b0;
        chk(busy && !rf_rd_en && !rf_we, "R8 q1", {busy, rf_rd_en, rf_we}, 3'b100);
        @(negedge clk); // Q2
        chk(busy && rf_rd_en && !rf_we, "R8 q2", {busy, rf_rd_en, rf_we}, 3'b110);
        if (is_ror || is_set)
            chk(int'(rf_addr) == ea, ins[8] ? "R5 addr" : "R6/R7 addr", rf_addr, ea);
        if (poke) begin
            start = 1'b1;
            instr = 16'h6833; // fill at 033h if it were accepted
        end
        @(negedge clk); // Q3
        start = 1'b0;
        chk(busy && !rf_rd_en && !rf_we, "R8 q3", {busy, rf_rd_en, rf_we}, 3'b100);
        @(negedge clk); // Q4
        if (is_ror || is_set) begin
            if (is_set || ins[9]) begin
                chk(rf_we && int'(rf_addr) == ea, "R2/R4 write strobe", rf_addr, ea);
                chk(rf_wdata == res, is_set ? "R4 data" : "R1 data", rf_wdata, res);
                exp_mem = res;
            end else begin
                chk(!rf_we, "R2 no file write", rf_we, 0);
            end
        end else begin
            chk(!rf_we, "R9 no write", rf_we, 0);
        end
        if (is_ror) begin
            if (!ins[9]) exp_w = res;
            exp_n = res[7];
            exp_z = (res == 8'h00);
        end
        @(negedge clk); // after
        chk(done && !busy, "R8 done", {done, busy}, 2'b10);
        chk(w_q == exp_w, "R1/R2 working reg", w_q, exp_w);
        chk(flag_n == exp_n && flag_z == exp_z, "R3/R4/R9 flags",
            {flag_n, flag_z}, {exp_n, exp_z});
        chk(rd(ea) == exp_mem, "R2/R4 memory", rd(ea), exp_mem);
        @(negedge clk);
        chk(!done && !busy, "R8/R10 idle after done", {done, busy}, 2'b00);
        if (poke) chk(rd(32'h033) == 8'h11, "R10 start ignored", rd(32'h033), 8'h11);
    endtask

    task automatic finish_run();
        if (finished) return;
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        rst = 1'b1; start = 1'b0; instr = '0; ext_en = 1'b0;
        bank_sel = 4'h5; idx_base = 12'h000; rf_rdata = '0;
        mem[32'h020] = 8'hD7; mem[32'h021] = 8'h01; mem[32'h022] = 8'h00;
        mem[32'h345] = 8'h02; mem[32'hF80] = 8'hAA; mem[32'h010] = 8'h5A;
        mem[32'h7C3] = 8'h00; mem[32'h105] = 8'h03; mem[32'h04F] = 8'h12;
        mem[32'hF60] = 8'h10; mem[32'h205] = 8'h44; mem[32'h033] = 8'h11;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!busy && !done && !rf_rd_en && !rf_we, "R11 reset strobes",
            {busy, done, rf_rd_en, rf_we}, 0);
        chk(w_q == 8'h00 && !flag_n && !flag_z, "R11 reset regs", {w_q, flag_n, flag_z}, 0);
        rst = 1'b0;
        @(negedge clk);
        run(16'h4220, 0);          // R1 rotate D7 -> EB back to file, shared low
        run(16'h4021, 0);          // R2 rotate to W, 01 -> 80
        run(16'h4022, 0);          // R3 zero result
        run(16'h6810, 0);          // R4 fill, Z stays set
        bank_sel = 4'h3;
        run(16'h4345, 0);          // R5 banked address 345h
        bank_sel = 4'h5;
        run(16'h4280, 0);          // R6 high half F80h, bank ignored
        bank_sel = 4'h7;
        run(16'h69C3, 0);          // R5 fill at 7C3h
        ext_en = 1'b1; idx_base = 12'h100;
        run(16'h4205, 0);          // R7 indexed 105h
        idx_base = 12'hFF0;
        run(16'h685F, 0);          // R7 indexed wrap to 04Fh
        run(16'h4060, 0);          // R7 field 60h not indexed -> F60h
        bank_sel = 4'h2;
        run(16'h6905, 0);          // R7 banked overrides indexing -> 205h
        ext_en = 1'b0;
        run(16'h1234, 0);          // R9 unknown opcode
        run(16'h4021, 1);          // R10 start while busy
        finish_run();
    end
endmodule